// File: doc/BRIEF.md
# Prescaled Timer Counter Core

A 32-bit up-counter that advances on qualified functional-clock ticks, optionally slowed by a power-of-two prescaler. When the count passes its all-ones value the block either reloads from a load register and keeps going, or stops and returns to zero. A compare register raises a match event. The register bus can also write the count directly, or force a reload by writing to a trigger address.

Three event sources (match, overflow, and a capture pulse supplied by a neighbouring capture unit) feed a status register. A status bit is set only when its interrupt enable is set, and software clears it by writing a one to it. The interrupt line stays high while any status bit is set. A separate wakeup enable turns any event into a one-cycle wakeup pulse, whatever the interrupt masking. The bus is a single-cycle register port: a write takes effect at the clock edge that samples it, and read data is combinational from the current register state.

Top module: `ptmr_core`

## Requirements
- R1: After hardware reset, and after a write with bit 1 set to offset 0x10, every register reads zero, irq is low and the counter is stopped. Offset 0x10 itself reads zero.
- R2: With start (control bit 0) set and the prescaler off, the counter at 0x28 increases by one in each cycle where fclk_tick is high, and holds when fclk_tick is low or start is clear. A bus write to 0x28 loads the counter and takes priority over a count step in that cycle.
- R3: With prescale enable (control bit 5) set, the counter advances once every 2^(P+1) qualified ticks, where P is control bits 4:2. The prescaler restarts from zero on any write to control, counter or trigger.
- R4: On a step from 0xFFFFFFFF with auto-reload (control bit 1) set, the counter takes the load value (0x2C), keeps running, and an overflow event is raised.
- R5: On a step from 0xFFFFFFFF with auto-reload clear, the counter becomes zero, the start bit clears, and an overflow event is raised.
- R6: With compare enable (control bit 6) set, a step whose resulting count equals the match register (0x38) raises a match event. With the bit clear, no match event occurs.
- R7: Any write to 0x30 loads the counter from the load register. Reading 0x30 returns 0xFFFFFFFF.
- R8: Status (0x18) holds bit 0 match, bit 1 overflow and bit 2 capture (cap_evt). A bit is set one edge after its event, and only if the same bit of the interrupt enable register (0x1C, bits 2:0 kept) is set. irq is high exactly while status is nonzero.
- R9: Writing ones to 0x18 clears those status bits. An event in the same cycle as the clear leaves its bit set.
- R10: The wakeup enable register (0x20, bits 2:0 kept) makes wake pulse high for one cycle, on the edge after any enabled event, independent of the interrupt enables.
- R11: Unmapped offsets read zero and ignore writes. The control register keeps and returns only bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fclk_tick | input | 1 | Functional-clock tick qualifier |
| cap_evt | input | 1 | Capture event pulse from the capture unit |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt level |
| wake | output | 1 | Wakeup pulse |

## Verification
A register write is visible on a read in the cycle after its sampling edge. A count step, reload or stop shows at the edge that ends the cycle in which the step qualifies. Status, irq and wake follow that same edge, so they change together with the counter. The bench updates a behavioural model at each rising edge. It compares irq, wake and any read data against the model state before that edge is applied, and it drives all inputs on falling edges, so each result is sampled exactly in the cycle it is due.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int PTV_W    = 3;
    localparam int EV_N     = 3;
    localparam int EV_MAT   = 0;
    localparam int EV_OVF   = 1;
    localparam int EV_CAP   = 2;
    localparam int SRST_BIT = 1;

    localparam int OFF_SYS   = 'h10;
    localparam int OFF_STS   = 'h18;
    localparam int OFF_IE    = 'h1C;
    localparam int OFF_WE    = 'h20;
    localparam int OFF_CTRL  = 'h24;
    localparam int OFF_CNT   = 'h28;
    localparam int OFF_LOAD  = 'h2C;
    localparam int OFF_TRIG  = 'h30;
    localparam int OFF_MATCH = 'h38;

    // bit order is the control register layout: start at bit 0
    typedef struct packed {
        logic             cmp_en;
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
        logic             auto_rld;
        logic             start;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
#(
    parameter int SEL_W = PTV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic             pre_en,
    input  logic [SEL_W-1:0] ptv,
    output logic             step
);
    localparam int DIV_W = 1 << SEL_W;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] limit;

    // 2^(ptv+1)-1 : shift an all-ones word right by (DIV_W-1-ptv) == ~ptv
    assign limit = {DIV_W{1'b1}} >> (~ptv);

    always_comb begin
        div_d = div_q;
        step  = 1'b0;
        if (clear || !run) begin
            div_d = '0;
        end else if (tick) begin
            if (!pre_en) begin
                step  = 1'b1;
                div_d = '0;
            end else if (div_q == limit) begin
                step  = 1'b1;
                div_d = '0;
            end else begin
                div_d = div_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (div_q == '0));

    p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && $stable(ptv)) |-> (div_q <= limit));
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_cnt,
    input  logic              wr_trig,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] match_val,
    input  logic              cmp_en,
    input  logic              auto_rld,
    input  logic              step,
    output logic [DATA_W-1:0] cnt_q,
    output logic              ovf_evt,
    output logic              mat_evt,
    output logic              stop_req
);
    logic [DATA_W-1:0] cnt_d;

    always_comb begin
        cnt_d    = cnt_q;
        ovf_evt  = 1'b0;
        mat_evt  = 1'b0;
        stop_req = 1'b0;
        if (soft_rst) begin
            cnt_d = '0;
        end else if (wr_cnt) begin
            cnt_d = wdata;
        end else if (wr_trig) begin
            cnt_d = load_val;
        end else if (step) begin
            if (cnt_q == {DATA_W{1'b1}}) begin
                ovf_evt = 1'b1;
                if (auto_rld) begin
                    cnt_d = load_val;
                end else begin
                    cnt_d    = '0;
                    stop_req = 1'b1;
                end
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
            mat_evt = cmp_en && (cnt_d == match_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !soft_rst && !wr_cnt && !wr_trig && cnt_q != {DATA_W{1'b1}})
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_ovf_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && auto_rld) |=> (cnt_q == $past(load_val)));

    p_ovf_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !auto_rld) |=> (cnt_q == '0));
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic [EV_N-1:0]   sts_val,
    input  logic              stop_req,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] match_val,
    output logic [EV_N-1:0]   ie,
    output logic [EV_N-1:0]   we,
    output logic              wr_ctrl,
    output logic              wr_cnt,
    output logic              wr_trig,
    output logic              wr_sts,
    output logic              soft_rst
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] match;
        logic [EV_N-1:0]   ie;
        logic [EV_N-1:0]   we;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit;

    assign hit = bus_sel && bus_wr;

    always_comb begin
        st_d     = st_q;
        wr_ctrl  = 1'b0;
        wr_cnt   = 1'b0;
        wr_trig  = 1'b0;
        wr_sts   = 1'b0;
        soft_rst = hit && (bus_addr == ADDR_W'(OFF_SYS)) && bus_wdata[SRST_BIT];
        if (soft_rst) begin
            st_d = '0;
        end else begin
            if (stop_req) st_d.ctrl.start = 1'b0;
            if (hit) begin
                case (bus_addr)
                    ADDR_W'(OFF_CTRL): begin
                        st_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                        wr_ctrl   = 1'b1;
                    end
                    ADDR_W'(OFF_LOAD):  st_d.load  = bus_wdata;
                    ADDR_W'(OFF_MATCH): st_d.match = bus_wdata;
                    ADDR_W'(OFF_IE):    st_d.ie    = bus_wdata[EV_N-1:0];
                    ADDR_W'(OFF_WE):    st_d.we    = bus_wdata[EV_N-1:0];
                    ADDR_W'(OFF_CNT):   wr_cnt     = 1'b1;
                    ADDR_W'(OFF_TRIG):  wr_trig    = 1'b1;
                    ADDR_W'(OFF_STS):   wr_sts     = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFF_STS):   bus_rdata = DATA_W'(sts_val);
                ADDR_W'(OFF_IE):    bus_rdata = DATA_W'(st_q.ie);
                ADDR_W'(OFF_WE):    bus_rdata = DATA_W'(st_q.we);
                ADDR_W'(OFF_CTRL):  bus_rdata = DATA_W'(st_q.ctrl);
                ADDR_W'(OFF_CNT):   bus_rdata = cnt_val;
                ADDR_W'(OFF_LOAD):  bus_rdata = st_q.load;
                ADDR_W'(OFF_TRIG):  bus_rdata = {DATA_W{1'b1}};
                ADDR_W'(OFF_MATCH): bus_rdata = st_q.match;
                default:            bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl      = st_q.ctrl;
    assign load_val  = st_q.load;
    assign match_val = st_q.match;
    assign ie        = st_q.ie;
    assign we        = st_q.we;

    p_stop_clears_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !soft_rst) |=> !st_q.ctrl.start);

    p_soft_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q == '0));
endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq
    import ptmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic [EV_N-1:0] evt,
    input  logic [EV_N-1:0] ie,
    input  logic [EV_N-1:0] we,
    input  logic            wr_sts,
    input  logic [EV_N-1:0] clr_bits,
    output logic [EV_N-1:0] sts,
    output logic            irq,
    output logic            wake
);
    typedef struct packed {
        logic [EV_N-1:0] sts;
        logic            wake;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_sts) st_d.sts = st_q.sts & ~clr_bits;
        st_d.sts  = st_d.sts | (evt & ie);
        st_d.wake = |(evt & we);
        if (soft_rst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts  = st_q.sts;
    assign irq  = |st_q.sts;
    assign wake = st_q.wake;

    p_set_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((st_q.sts & ~$past(st_q.sts) & ~$past(ie)) == '0));

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && ((clr_bits & evt & ie) == '0)) |=> ((st_q.sts & $past(clr_bits)) == '0));

    p_wake_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(evt & we) != '0));
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fclk_tick,
    input  logic              cap_evt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] load_val, match_val, cnt_val;
    logic [EV_N-1:0]   ie, we, sts, evt;
    logic              wr_ctrl, wr_cnt, wr_trig, wr_sts, soft_rst;
    logic              psc_clear, step, ovf_evt, mat_evt, stop_req;

    ptmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt_val(cnt_val), .sts_val(sts),
        .stop_req(stop_req), .bus_rdata(bus_rdata), .ctrl(ctrl),
        .load_val(load_val), .match_val(match_val), .ie(ie), .we(we),
        .wr_ctrl(wr_ctrl), .wr_cnt(wr_cnt), .wr_trig(wr_trig),
        .wr_sts(wr_sts), .soft_rst(soft_rst)
    );

    assign psc_clear = soft_rst || wr_ctrl || wr_cnt || wr_trig;

    ptmr_prescaler #(.SEL_W(PTV_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clear(psc_clear), .run(ctrl.start),
        .tick(fclk_tick), .pre_en(ctrl.pre_en), .ptv(ctrl.ptv), .step(step)
    );

    ptmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_cnt(wr_cnt), .wr_trig(wr_trig), .wdata(bus_wdata),
        .load_val(load_val), .match_val(match_val),
        .cmp_en(ctrl.cmp_en), .auto_rld(ctrl.auto_rld), .step(step),
        .cnt_q(cnt_val), .ovf_evt(ovf_evt), .mat_evt(mat_evt),
        .stop_req(stop_req)
    );

    assign evt[EV_MAT] = mat_evt;
    assign evt[EV_OVF] = ovf_evt;
    assign evt[EV_CAP] = cap_evt;

    ptmr_irq u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt(evt),
        .ie(ie), .we(we), .wr_sts(wr_sts), .clr_bits(bus_wdata[EV_N-1:0]),
        .sts(sts), .irq(irq), .wake(wake)
    );
endmodule

// File: tb/ptmr_core_bench.sv
module ptmr_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fclk_tick = 1'b0;
    logic        cap_evt = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    always #10 clk = ~clk;

    ptmr_core u_ptmr_core (
        .clk(clk), .rst_n(rst_n), .fclk_tick(fclk_tick), .cap_evt(cap_evt),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_cnt, m_load, m_match;
    logic [6:0]  m_ctrl;
    logic [2:0]  m_ie, m_we, m_sts;
    logic        m_wake;
    int          m_div;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h18: return {29'd0, m_sts};
            8'h1C: return {29'd0, m_ie};
            8'h20: return {29'd0, m_we};
            8'h24: return {25'd0, m_ctrl};
            8'h28: return m_cnt;
            8'h2C: return m_load;
            8'h30: return 32'hFFFF_FFFF;
            8'h38: return m_match;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic        hit, clr, step;
        logic [2:0]  evt;
        logic [31:0] n_cnt;
        logic [6:0]  n_ctrl;
        if (!rst_n) begin
            m_cnt = '0; m_load = '0; m_match = '0; m_ctrl = '0;
            m_ie = '0; m_we = '0; m_sts = '0; m_wake = 1'b0; m_div = 0;
        end else begin
            check("R8", "irq", {31'd0, irq}, {31'd0, |m_sts});
            check("R10", "wake", {31'd0, wake}, {31'd0, m_wake});
            if (bus_sel && !bus_wr)
                check(cur_req, $sformatf("read %h", bus_addr), bus_rdata, exp_read(bus_addr));
            hit = bus_sel && bus_wr;
            if (hit && bus_addr == 8'h10 && bus_wdata[1]) begin
                m_cnt = '0; m_load = '0; m_match = '0; m_ctrl = '0;
                m_ie = '0; m_we = '0; m_sts = '0; m_wake = 1'b0; m_div = 0;
            end else begin
                clr  = hit && (bus_addr == 8'h24 || bus_addr == 8'h28 || bus_addr == 8'h30);
                step = 1'b0;
                if (m_ctrl[0] && !clr && fclk_tick) begin
                    if (!m_ctrl[5]) step = 1'b1;
                    else if (m_div == (2 << m_ctrl[4:2]) - 1) begin step = 1'b1; m_div = 0; end
                    else m_div++;
                end
                if (clr || !m_ctrl[0]) m_div = 0;
                evt    = 3'b000;
                n_cnt  = m_cnt;
                n_ctrl = m_ctrl;
                if (hit && bus_addr == 8'h28) n_cnt = bus_wdata;
                else if (hit && bus_addr == 8'h30) n_cnt = m_load;
                else if (step) begin
                    if (m_cnt == 32'hFFFF_FFFF) begin
                        evt[1] = 1'b1;
                        if (m_ctrl[1]) n_cnt = m_load;
                        else begin n_cnt = '0; n_ctrl[0] = 1'b0; end
                    end else n_cnt = m_cnt + 1;
                    if (m_ctrl[6] && n_cnt == m_match) evt[0] = 1'b1;
                end
                evt[2] = cap_evt;
                m_sts  = (m_sts & ~((hit && bus_addr == 8'h18) ? bus_wdata[2:0] : 3'b000)) | (evt & m_ie);
                m_wake = |(evt & m_we);
                if (hit && bus_addr == 8'h24) n_ctrl = bus_wdata[6:0];
                if (hit && bus_addr == 8'h2C) m_load = bus_wdata;
                if (hit && bus_addr == 8'h38) m_match = bus_wdata;
                if (hit && bus_addr == 8'h1C) m_ie = bus_wdata[2:0];
                if (hit && bus_addr == 8'h20) m_we = bus_wdata[2:0];
                m_cnt  = n_cnt;
                m_ctrl = n_ctrl;
            end
        end
    end

    // all tasks start and end just after a falling edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [7:0] a);
        cur_req = req;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks_random(int n);
        repeat (n) begin
            fclk_tick = 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        fclk_tick = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(64'd200000 * 20);
        errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        foreach (exp_read_list[i]) rd("R1", exp_read_list[i]);
        rd("R1", 8'h10);

        // R11: unmapped and control width
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h5);
        rd("R11", 8'h04);
        rd("R11", 8'h3C);
        wr(8'h24, 32'hFFFF_FF80);
        rd("R11", 8'h24);

        // R8 / R10: enable register width
        wr(8'h1C, 32'hFFFF_FFFF);
        rd("R8", 8'h1C);
        wr(8'h20, 32'h0000_00FF);
        rd("R10", 8'h20);
        wr(8'h1C, 0);
        wr(8'h20, 0);

        // R2: plain counting
        fclk_tick = 1'b1;
        wr(8'h28, 32'h10);
        wr(8'h24, 32'h01);
        idle(5);
        rd("R2", 8'h28);
        ticks_random(20);
        rd("R2", 8'h28);
        fclk_tick = 1'b0;
        idle(3);
        rd("R2", 8'h28);
        fclk_tick = 1'b1;
        wr(8'h28, 32'h200);
        rd("R2", 8'h28);

        // R3: prescaler
        wr(8'h24, 32'h21);
        idle(9);
        rd("R3", 8'h28);
        wr(8'h24, 32'h29);
        idle(30);
        rd("R3", 8'h28);
        ticks_random(40);
        rd("R3", 8'h28);
        wr(8'h24, 32'h3D);
        idle(300);
        rd("R3", 8'h28);

        // R4: overflow with reload
        wr(8'h24, 0);
        wr(8'h1C, 7);
        wr(8'h2C, 32'h100);
        wr(8'h28, 32'hFFFF_FFFA);
        wr(8'h24, 32'h03);
        idle(10);
        rd("R4", 8'h28);
        rd("R4", 8'h18);

        // R9: clear, and clear colliding with overflow
        wr(8'h18, 32'h2);
        rd("R9", 8'h18);
        wr(8'h24, 0);
        wr(8'h28, 32'hFFFF_FFFE);
        wr(8'h24, 32'h03);
        idle(1);
        wr(8'h18, 32'h2);
        rd("R9", 8'h18);
        wr(8'h18, 32'h7);
        rd("R9", 8'h18);

        // R5: overflow without reload
        wr(8'h24, 0);
        wr(8'h28, 32'hFFFF_FFFC);
        wr(8'h24, 32'h01);
        idle(10);
        rd("R5", 8'h28);
        rd("R5", 8'h24);
        rd("R5", 8'h18);
        wr(8'h18, 32'h7);

        // R6: match enabled and disabled
        wr(8'h38, 32'h40);
        wr(8'h28, 32'h30);
        wr(8'h24, 32'h41);
        idle(30);
        rd("R6", 8'h18);
        wr(8'h18, 32'h1);
        wr(8'h28, 32'h30);
        wr(8'h24, 32'h01);
        idle(30);
        rd("R6", 8'h18);

        // R10: wakeup without interrupt enable
        wr(8'h1C, 0);
        wr(8'h20, 7);
        wr(8'h28, 32'h30);
        wr(8'h24, 32'h41);
        idle(30);
        rd("R10", 8'h18);
        wr(8'h20, 0);

        // R8: capture event
        wr(8'h1C, 4);
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        rd("R8", 8'h18);
        wr(8'h18, 32'h4);
        rd("R8", 8'h18);

        // R7: trigger reload
        wr(8'h24, 0);
        wr(8'h2C, 32'h1234);
        wr(8'h30, 0);
        rd("R7", 8'h28);
        rd("R7", 8'h30);
        wr(8'h24, 32'h01);
        idle(4);
        wr(8'h30, 32'hDEAD);
        rd("R7", 8'h28);

        // R1: soft reset
        wr(8'h1C, 7);
        wr(8'h18, 0);
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        wr(8'h10, 32'h2);
        foreach (exp_read_list[i]) rd("R1", exp_read_list[i]);
        idle(2);

        finish_run();
    end

    logic [7:0] exp_read_list [8] = '{8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h38};
endmodule